// File: doc/BRIEF.md
# Pad attribute register bank

This block stores the electrical attribute word for every pad of a chip's IO ring. There are two groups of pads. Multiplexed pads can be routed to different peripherals, and dedicated pads have fixed owners. Each group has its own register array and its own flat attribute output vector. The pad ring reads these vectors directly. Software sets the attributes through a small single-cycle register bus. Each request is marked valid and carries a write flag, a word address and write data.

Writes follow a write-any-read-legal policy. Any bit that the selected implementation mode does not support is cleared before it is stored. A reserved bit therefore never reaches a pad, and it never reads back as one. A build-time parameter selects either the generic mode or the FPGA mode, and each mode has its own set of legal bits. Every request gets a registered response one cycle later. A read returns the stored word. An address that maps to no register returns zero and raises an error flag.

Top module: `pad_attr_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every attribute output, `rsp_vld`, `rsp_err` and `rsp_rdata` read zero. Reset is synchronous and active high.
- R2: A valid write to address `a`, where `a < N_MUX`, sets byte `a` of `mux_attr` to the legalised data on the next clock edge. No other pad changes.
- R3: A valid write to address `N_MUX + j`, where `j < N_DED`, sets byte `j` of `ded_attr` to the legalised data on the next clock edge. No other pad changes.
- R4: The attribute word is 8 bits. Bit 0 is invert, bit 1 is open-drain, bit 2 is pull enable and bit 3 is pull select. Bits 7:4 are reserved and are always zero on every output and in every read.
- R5: When `FPGA_MODE` is 0, the legal bits are 3:0. When `FPGA_MODE` is 1, only bits 1:0 are legal and bits 7:2 are always zero.
- R6: An attribute output changes only on the clock edge that follows a valid write to that group's address range. Reads and idle cycles leave it unchanged.
- R7: Each valid request gives `rsp_vld` high for exactly the next cycle. For a mapped read, `rsp_rdata` then carries the stored, legalised word. For a write, `rsp_rdata` is zero.
- R8: A valid access to an address `>= N_MUX + N_DED` gives `rsp_err` high and `rsp_rdata` zero in the response cycle. It modifies no register.
- R9: A request with `req_vld` low has no effect on any register or output, whatever its write flag, address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8 | Write data |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 8 | Read data |
| rsp_err | output | 1 | Unmapped address in the previous request |
| mux_attr | output | 8*N_MUX | Attribute words of the multiplexed pads |
| ded_attr | output | 8*N_DED | Attribute words of the dedicated pads |

## Verification
The bench builds two copies of the block side by side on one shared bus, with N_MUX=6, N_DED=3 and ADDR_W=5. One copy is in generic mode and the other is in FPGA mode. The same all-ones write therefore shows both legal masks at once. Because the pad counts are not powers of two, the map has unmapped addresses inside the index range (9 to 15) as well as above it (up to 31). The boundaries between the two groups, at 5/6 and 8/9, are hit directly as well as by random traffic.

// File: rtl/pad_attr_pkg.sv
package pad_attr_pkg;
  localparam int ATTR_W = 8;

  localparam int BIT_INV     = 0;
  localparam int BIT_ODRAIN  = 1;
  localparam int BIT_PULL_EN = 2;
  localparam int BIT_PULL_UP = 3;

  typedef logic [ATTR_W-1:0] attr_t;

  // Bits that the given build mode implements; all others are reserved.
  function automatic attr_t legal_mask(input bit fpga_mode);
    attr_t m;
    m = '0;
    m[BIT_INV]    = 1'b1;
    m[BIT_ODRAIN] = 1'b1;
    if (!fpga_mode) begin
      m[BIT_PULL_EN] = 1'b1;
      m[BIT_PULL_UP] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pad_attr_decode.sv
module pad_attr_decode #(
  parameter int N_MUX  = 8,
  parameter int N_DED  = 4,
  parameter int ADDR_W = 6,
  localparam int MI_W = (N_MUX > 1) ? $clog2(N_MUX) : 1,
  localparam int DI_W = (N_DED > 1) ? $clog2(N_DED) : 1,
  localparam int TOTAL = N_MUX + N_DED
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_mux,
  output logic              hit_ded,
  output logic              miss,
  output logic [MI_W-1:0]   mux_idx,
  output logic [DI_W-1:0]   ded_idx
);
  logic [ADDR_W-1:0] ded_off;

  always_comb begin
    hit_mux = addr < ADDR_W'(N_MUX);
    hit_ded = !hit_mux && (addr < ADDR_W'(TOTAL));
    miss    = !hit_mux && !hit_ded;
    ded_off = addr - ADDR_W'(N_MUX);
    mux_idx = MI_W'(addr);
    ded_idx = DI_W'(ded_off);
  end
endmodule

// File: rtl/pad_attr_regs.sv
module pad_attr_regs
  import pad_attr_pkg::*;
#(
  parameter int N    = 8,
  parameter bit FPGA = 1'b0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   wr_idx,
  input  attr_t           wdata,
  input  logic [IW-1:0]   rd_idx,
  output attr_t           rd_data,
  output logic [N*ATTR_W-1:0] q
);
  localparam attr_t MASK = legal_mask(FPGA);

  attr_t mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wdata & MASK;
    end
  end

  assign rd_data = mem[rd_idx];

  for (genvar g = 0; g < N; g++) begin : g_out
    assign q[g*ATTR_W +: ATTR_W] = mem[g];
  end
endmodule

// File: rtl/pad_attr_bank.sv
module pad_attr_bank
  import pad_attr_pkg::*;
#(
  parameter int N_MUX     = 8,
  parameter int N_DED     = 4,
  parameter int ADDR_W    = 6,
  parameter bit FPGA_MODE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_vld,
  input  logic                    req_wr,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [ATTR_W-1:0]       req_wdata,
  output logic                    rsp_vld,
  output logic [ATTR_W-1:0]       rsp_rdata,
  output logic                    rsp_err,
  output logic [N_MUX*ATTR_W-1:0] mux_attr,
  output logic [N_DED*ATTR_W-1:0] ded_attr
);
  localparam int MI_W = (N_MUX > 1) ? $clog2(N_MUX) : 1;
  localparam int DI_W = (N_DED > 1) ? $clog2(N_DED) : 1;

  logic            hit_mux, hit_ded, miss;
  logic [MI_W-1:0] mux_idx;
  logic [DI_W-1:0] ded_idx;
  attr_t           mux_rd, ded_rd, rd_sel;

  pad_attr_decode #(.N_MUX(N_MUX), .N_DED(N_DED), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .hit_mux(hit_mux), .hit_ded(hit_ded), .miss(miss),
    .mux_idx(mux_idx), .ded_idx(ded_idx)
  );

  pad_attr_regs #(.N(N_MUX), .FPGA(FPGA_MODE)) u_mux (
    .clk(clk), .rst(rst), .we(req_vld && req_wr && hit_mux),
    .wr_idx(mux_idx), .wdata(req_wdata), .rd_idx(mux_idx),
    .rd_data(mux_rd), .q(mux_attr)
  );

  pad_attr_regs #(.N(N_DED), .FPGA(FPGA_MODE)) u_ded (
    .clk(clk), .rst(rst), .we(req_vld && req_wr && hit_ded),
    .wr_idx(ded_idx), .wdata(req_wdata), .rd_idx(ded_idx),
    .rd_data(ded_rd), .q(ded_attr)
  );

  always_comb begin
    rd_sel = '0;
    if (!req_wr) begin
      if (hit_mux)      rd_sel = mux_rd;
      else if (hit_ded) rd_sel = ded_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_vld   <= req_vld;
      rsp_err   <= req_vld && miss;
      rsp_rdata <= req_vld ? rd_sel : '0;
    end
  end
endmodule

// File: rtl/pad_attr_chk.sv
module pad_attr_chk
  import pad_attr_pkg::*;
#(
  parameter int N_MUX     = 8,
  parameter int N_DED     = 4,
  parameter int ADDR_W    = 6,
  parameter bit FPGA_MODE = 1'b0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_vld,
  input logic                    req_wr,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    rsp_vld,
  input logic [ATTR_W-1:0]       rsp_rdata,
  input logic                    rsp_err,
  input logic [N_MUX*ATTR_W-1:0] mux_attr,
  input logic [N_DED*ATTR_W-1:0] ded_attr
);
  localparam int TOTAL = N_MUX + N_DED;
  localparam attr_t ILLEGAL = ~legal_mask(FPGA_MODE);

  logic illegal_seen;
  always_comb begin
    illegal_seen = (rsp_rdata & ILLEGAL) != '0;
    for (int i = 0; i < N_MUX; i++)
      if ((mux_attr[i*ATTR_W +: ATTR_W] & ILLEGAL) != '0) illegal_seen = 1'b1;
    for (int i = 0; i < N_DED; i++)
      if ((ded_attr[i*ATTR_W +: ATTR_W] & ILLEGAL) != '0) illegal_seen = 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mux_attr == '0 && ded_attr == '0 && !rsp_vld && !rsp_err));

  // R4 and R5
  a_r4_reserved_low: assert property (@(posedge clk) disable iff (rst)
    !illegal_seen);

  a_r6_mux_needs_write: assert property (@(posedge clk) disable iff (rst)
    (mux_attr != $past(mux_attr)) |->
      $past(req_vld && req_wr && req_addr < ADDR_W'(N_MUX)));

  a_r6_ded_needs_write: assert property (@(posedge clk) disable iff (rst)
    (ded_attr != $past(ded_attr)) |->
      $past(req_vld && req_wr && req_addr >= ADDR_W'(N_MUX) && req_addr < ADDR_W'(TOTAL)));

  a_r7_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> (!rsp_vld && !rsp_err && $stable(mux_attr) && $stable(ded_attr)));

  a_r8_unmapped: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_addr >= ADDR_W'(TOTAL)) |=>
      (rsp_err && rsp_rdata == '0 && $stable(mux_attr) && $stable(ded_attr)));
endmodule

bind pad_attr_bank pad_attr_chk #(
  .N_MUX(N_MUX), .N_DED(N_DED), .ADDR_W(ADDR_W), .FPGA_MODE(FPGA_MODE)
) u_chk (.*);

// File: tb/sim_pad_attr_bank.sv
`timescale 1ns/1ps
module sim_pad_attr_bank;
  localparam int NM = 6;
  localparam int ND = 3;
  localparam int AW = 5;
  localparam int NT = NM + ND;

  logic clk = 0, rst = 1;
  logic req_vld = 0, req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;

  logic rv0, re0, rv1, re1;
  logic [7:0] rd0, rd1;
  logic [NM*8-1:0] ma0, ma1;
  logic [ND*8-1:0] da0, da1;

  int total = 0, bad = 0;
  logic [7:0] mg [NT];
  logic [7:0] mf [NT];

  always #2.5 clk = ~clk;

  pad_attr_bank #(.N_MUX(NM), .N_DED(ND), .ADDR_W(AW), .FPGA_MODE(1'b0)) u0 (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_vld(rv0), .rsp_rdata(rd0), .rsp_err(re0),
    .mux_attr(ma0), .ded_attr(da0));

  pad_attr_bank #(.N_MUX(NM), .N_DED(ND), .ADDR_W(AW), .FPGA_MODE(1'b1)) u1 (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_vld(rv1), .rsp_rdata(rd1), .rsp_err(re1),
    .mux_attr(ma1), .ded_attr(da1));

  function automatic logic [7:0] legal(input logic [7:0] d, input bit fpga);
    return d & (fpga ? 8'h03 : 8'h0F);
  endfunction

  function automatic logic [63:0] mux_vec(input bit fpga);
    logic [63:0] v = '0;
    for (int i = 0; i < NM; i++) v[i*8 +: 8] = fpga ? mf[i] : mg[i];
    return v;
  endfunction

  function automatic logic [63:0] ded_vec(input bit fpga);
    logic [63:0] v = '0;
    for (int i = 0; i < ND; i++) v[i*8 +: 8] = fpga ? mf[NM+i] : mg[NM+i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk({req, " mux generic"}, 64'(ma0), mux_vec(0));
    chk({req, " ded generic"}, 64'(da0), ded_vec(0));
    chk({req, " mux fpga"},    64'(ma1), mux_vec(1));
    chk({req, " ded fpga"},    64'(da1), ded_vec(1));
  endtask

  // One bus cycle; checks response and outputs after the edge that takes it.
  task automatic op(input bit v, input bit wr, input int a, input logic [7:0] d, input string req);
    logic [7:0] eg, ef;
    bit mapped;
    @(negedge clk);
    req_vld = v; req_wr = wr; req_addr = AW'(a); req_wdata = d;
    mapped = a < NT;
    eg = (v && !wr && mapped) ? mg[a] : 8'h00;
    ef = (v && !wr && mapped) ? mf[a] : 8'h00;
    if (v && wr && mapped) begin
      mg[a] = legal(d, 0);
      mf[a] = legal(d, 1);
    end
    @(negedge clk);
    req_vld = 0;
    chk({req, " R7 rsp_vld"}, 64'({rv0, rv1}), 64'({v, v}));
    chk({req, " R8 rsp_err"}, 64'({re0, re1}), 64'({v && !mapped, v && !mapped}));
    chk({req, " R7 rdata"},   64'({rd0, rd1}), 64'({eg, ef}));
    chk_outputs(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin mg[i] = '0; mf[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_outputs("R1 reset held");
    chk("R1 rsp idle in reset", 64'({rv0, re0, rd0, rv1, re1, rd1}), 64'(0));
    rst = 0;
    @(negedge clk);
    chk_outputs("R1 after reset");

    // R2/R3/R4/R5 edges of each group with all-ones data
    op(1, 1, 0,      8'hFF, "R2 first mux");
    op(1, 1, NM-1,   8'hFF, "R2 last mux");
    op(1, 1, NM,     8'hFF, "R3 first ded");
    op(1, 1, NT-1,   8'hF5, "R3 last ded R4 R5");
    op(1, 0, NM-1,   8'h00, "R7 read last mux");
    op(1, 0, NM,     8'h00, "R7 read first ded");
    op(1, 0, NT-1,   8'h00, "R7 R4 read last ded");
    // R8 unmapped inside and above index range
    op(1, 1, NT,     8'hFF, "R8 unmapped 9 write");
    op(1, 0, 15,     8'h00, "R8 unmapped 15 read");
    op(1, 1, 31,     8'h0F, "R8 unmapped top write");
    // R9 idle with write-looking content
    op(0, 1, 0,      8'h00, "R9 idle write to 0");
    op(0, 1, NM,     8'h00, "R9 idle write to ded");
    // R6 read does not alter
    op(1, 0, 0,      8'hAA, "R6 read with data");
    op(1, 1, 1,      8'h0A, "R2 pull bits R5");

    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      bit v = ($urandom_range(0, 9) != 0);
      bit w = $urandom_range(0, 1);
      int a = ($urandom_range(0, 7) == 0) ? $urandom_range(NT, 31) : $urandom_range(0, NT-1);
      op(v, w, a, 8'($urandom), "R2 R3 R6 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule